// File: doc/BRIEF.md
# Transfer Job Splitter

This block takes memory transfer jobs, each a byte address and a byte length with no limits placed on either, and turns each one into a series of smaller jobs. Every output job fits within a power-of-two maximum length of at most 4096 bytes. No output job crosses a 4 KiB address boundary. Optionally, no output job has length zero. The block sits in front of a burst engine that can only handle jobs that are already legal as single bursts.

The splitting follows a fixed pattern. The first output piece is cut short so that it ends on the next multiple of the maximum length; if the job ends sooner, the first piece covers the whole job. Every following piece has the full maximum length, except the last, which carries whatever is left. Because every piece after the first starts on a maximum-length boundary, and the maximum length divides 4096, no piece can cross a 4 KiB boundary. The block never has to detect such a boundary. The cost is that some jobs split into one more piece than strictly necessary.

Both sides are valid/ready streams, and a transfer happens on a rising clock edge when valid and ready are both high.
- Once the block raises `dst_valid`, it holds `dst_valid`, `dst_addr` and `dst_bytes` unchanged until `dst_ready` is high.
- The block holds at most one input job at a time. It raises `src_ready` when it is empty, or in the same cycle that the last piece of the current job is being taken by downstream. This means `src_ready` depends combinationally on `dst_ready`.

Top module: `job_splitter`

## Requirements
- R1: During and right after reset, `dst_valid` is low and `src_ready` is high.
- R2: `dst_bytes` is never larger than `MAX_BYTES` and, for a non-zero input job, is never zero.
- R3: No output job crosses a 4096-byte address boundary, and no output job crosses a `MAX_BYTES` boundary.
- R4: The first piece of a job starts at the input address. Its length is the smaller of the input length and `MAX_BYTES` minus (address modulo `MAX_BYTES`).
- R5: Pieces after the first start exactly where the previous piece ended. Every piece that is neither first nor last is `MAX_BYTES` long.
- R6: The last piece carries the remaining bytes, so the piece lengths of a job add up to the input length. The block keeps `dst_valid` high until that last piece has been taken.
- R7: With `DROP_ZERO` = 1, an input job of length 0 is accepted and produces no output piece.
- R8: An input that starts on a `MAX_BYTES` boundary and is no longer than `MAX_BYTES` comes out as one unchanged piece.
- R9: `src_ready` is high exactly when no job is held, or when the last piece is presented with `dst_ready` high.
- R10: While `dst_valid` is high and `dst_ready` is low, `dst_valid`, `dst_addr` and `dst_bytes` keep their values into the next cycle.
- R11: With `MAX_BYTES` = 256, an input at address 128 with length 256 gives two pieces of 128 bytes each, at addresses 128 and 256.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_valid | input | 1 | An input job is offered |
| src_ready | output | 1 | The block takes the offered job this cycle |
| src_addr | input | ADDR_W | Byte address of the input job |
| src_bytes | input | LEN_W | Byte length of the input job |
| dst_valid | output | 1 | An output piece is offered |
| dst_ready | input | 1 | Downstream takes the piece this cycle |
| dst_addr | output | ADDR_W | Byte address of the output piece |
| dst_bytes | output | $clog2(MAX_BYTES)+1 | Byte length of the output piece |

## Verification
The assertions assume the following about the inputs:
- Upstream keeps `src_valid` and its job fields steady until the job is accepted.
- With `DROP_ZERO` = 0, no input job has length 0.
- An input job does not run past the top of the address space.

The stimulus keeps to these rules. It holds each job until the cycle in which it is accepted. It sends zero-length jobs only with zero filtering enabled. It draws random addresses from a range far below the address limit. It also varies the downstream ready rate from always-ready to heavy back-pressure.

// File: rtl/job_splitter_pkg.sv
package job_splitter_pkg;
  typedef enum logic {
    SPLT_EMPTY = 1'b0,
    SPLT_HOLD  = 1'b1
  } splt_state_e;
endpackage

// File: rtl/jsplit_piece_calc.sv
module jsplit_piece_calc #(
  parameter int ADDR_W    = 32,
  parameter int LEN_W     = 14,
  parameter int MAX_BYTES = 256
) (
  input  logic [ADDR_W-1:0]              cur_addr,
  input  logic [LEN_W-1:0]               cur_rem,
  output logic [$clog2(MAX_BYTES):0]     piece,
  output logic                           is_last
);
  localparam int OFFW   = $clog2(MAX_BYTES);
  localparam int OLEN_W = OFFW + 1;
  localparam int CW     = (LEN_W > OLEN_W) ? LEN_W : OLEN_W;

  logic [OFFW-1:0] offs;
  logic [CW-1:0]   room_w;
  logic [CW-1:0]   rem_w;
  logic [CW-1:0]   piece_w;

  always_comb begin
    offs    = cur_addr[OFFW-1:0];
    room_w  = CW'(MAX_BYTES) - CW'(offs);
    rem_w   = CW'(cur_rem);
    is_last = (rem_w <= room_w);
    piece_w = is_last ? rem_w : room_w;
    piece   = piece_w[OLEN_W-1:0];
  end
endmodule

// File: rtl/jsplit_zero_filter.sv
module jsplit_zero_filter #(
  parameter int LEN_W     = 14,
  parameter bit DROP_ZERO = 1'b1
) (
  input  logic [LEN_W-1:0] in_bytes,
  output logic             drop
);
  generate
    if (DROP_ZERO) begin : g_filter
      assign drop = (in_bytes == '0);
    end else begin : g_pass
      assign drop = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/jsplit_job_reg.sv
module jsplit_job_reg
  import job_splitter_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 14,
  parameter int STEP_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic [LEN_W-1:0]  load_bytes,
  input  logic              advance,
  input  logic              finish,
  input  logic [STEP_W-1:0] step,
  output logic              busy,
  output logic [ADDR_W-1:0] cur_addr,
  output logic [LEN_W-1:0]  cur_rem
);
  splt_state_e state_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= SPLT_EMPTY;
      cur_addr <= '0;
      cur_rem  <= '0;
    end else if (load) begin
      state_q  <= SPLT_HOLD;
      cur_addr <= load_addr;
      cur_rem  <= load_bytes;
    end else if (finish) begin
      state_q  <= SPLT_EMPTY;
    end else if (advance) begin
      cur_addr <= cur_addr + ADDR_W'(step);
      cur_rem  <= cur_rem - LEN_W'(step);
    end
  end

  assign busy = (state_q == SPLT_HOLD);
endmodule

// File: rtl/job_splitter.sv
module job_splitter #(
  parameter int ADDR_W    = 32,
  parameter int LEN_W     = 14,
  parameter int MAX_BYTES = 256,
  parameter bit DROP_ZERO = 1'b1
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          src_valid,
  output logic                          src_ready,
  input  logic [ADDR_W-1:0]             src_addr,
  input  logic [LEN_W-1:0]              src_bytes,
  output logic                          dst_valid,
  input  logic                          dst_ready,
  output logic [ADDR_W-1:0]             dst_addr,
  output logic [$clog2(MAX_BYTES):0]    dst_bytes
);
  localparam int OFFW   = $clog2(MAX_BYTES);
  localparam int OLEN_W = OFFW + 1;

  logic              busy;
  logic [ADDR_W-1:0] cur_addr;
  logic [LEN_W-1:0]  cur_rem;
  logic [OLEN_W-1:0] piece;
  logic              is_last;
  logic              drop;
  logic              take_piece;
  logic              finish;
  logic              load;

  jsplit_zero_filter #(.LEN_W(LEN_W), .DROP_ZERO(DROP_ZERO)) u_filter (
    .in_bytes (src_bytes),
    .drop     (drop)
  );

  jsplit_piece_calc #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .MAX_BYTES(MAX_BYTES)) u_calc (
    .cur_addr (cur_addr),
    .cur_rem  (cur_rem),
    .piece    (piece),
    .is_last  (is_last)
  );

  assign take_piece = busy & dst_ready;
  assign finish     = take_piece & is_last;
  assign src_ready  = ~busy | finish;
  assign load       = src_valid & src_ready & ~drop;

  jsplit_job_reg #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .STEP_W(OLEN_W)) u_reg (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (load),
    .load_addr  (src_addr),
    .load_bytes (src_bytes),
    .advance    (take_piece),
    .finish     (finish),
    .step       (piece),
    .busy       (busy),
    .cur_addr   (cur_addr),
    .cur_rem    (cur_rem)
  );

  assign dst_valid = busy;
  assign dst_addr  = cur_addr;
  assign dst_bytes = piece;

  assert_len_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    dst_valid |-> (dst_bytes != '0) && (int'(dst_bytes) <= MAX_BYTES));

  assert_no_cross_R3: assert property (@(posedge clk) disable iff (!rst_n)
    dst_valid |-> (int'(dst_addr[OFFW-1:0]) + int'(dst_bytes) <= MAX_BYTES));

  assert_contiguous_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (dst_valid && dst_ready && !src_ready) |=>
      (dst_valid && dst_addr == $past(dst_addr) + ADDR_W'($past(dst_bytes))));

  assert_ready_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (src_ready && dst_valid) |-> dst_ready);

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (dst_valid && !dst_ready) |=>
      (dst_valid && $stable(dst_addr) && $stable(dst_bytes)));

  generate
    if (DROP_ZERO) begin : g_zero_chk
      assert_zero_dropped_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (src_valid && src_ready && src_bytes == '0) |=> !dst_valid);
    end
  endgenerate
endmodule

// File: tb/job_splitter_tb_top.sv
module job_splitter_tb_top;
  localparam int ADDR_W = 32;
  localparam int LEN_W  = 14;
  localparam int MAXB   = 256;
  localparam int OLW    = $clog2(MAXB) + 1;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n = 1'b0;
  logic src_valid = 1'b0, dst_ready = 1'b0;
  logic src_ready, dst_valid;
  logic [ADDR_W-1:0] src_addr = '0, dst_addr;
  logic [LEN_W-1:0]  src_bytes = '0;
  logic [OLW-1:0]    dst_bytes;

  job_splitter #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .MAX_BYTES(MAXB), .DROP_ZERO(1'b1)) dut_i (
    .clk(clk), .rst_n(rst_n), .src_valid(src_valid), .src_ready(src_ready),
    .src_addr(src_addr), .src_bytes(src_bytes), .dst_valid(dst_valid),
    .dst_ready(dst_ready), .dst_addr(dst_addr), .dst_bytes(dst_bytes));

  longint job_a[$];
  longint job_l[$];
  int checks = 0, fails = 0;
  bit run = 0;
  int ready_pct = 100;

  bit     m_busy = 0, m_first = 0;
  longint m_addr = 0, m_rem = 0;
  int     m_id = 0, acc_id = 0;
  int     pieces[int];

  bit     prev_stall = 0;
  longint prev_addr = 0, prev_len = 0;

  bit nx_valid = 0, nx_ready = 0;
  longint nx_addr = 0, nx_len = 0;

  task automatic chk(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (run) begin
      longint room, piece;
      bit     last, exp_rdy;
      string  tag;
      room    = MAXB - (m_addr % MAXB);
      last    = (m_rem <= room);
      piece   = last ? m_rem : room;
      exp_rdy = !m_busy || (dst_ready && last);
      tag     = m_first ? "R4" : (last ? "R6" : "R5");

      chk(dst_valid == m_busy, "R6 valid", dst_valid, m_busy);
      chk(src_ready == exp_rdy, "R9 src_ready", src_ready, exp_rdy);
      if (m_busy && dst_valid) begin
        chk(longint'(dst_addr) == m_addr, {tag, " addr"}, dst_addr, m_addr);
        chk(longint'(dst_bytes) == piece, {tag, " bytes"}, dst_bytes, piece);
      end
      if (prev_stall) begin
        chk(dst_valid && longint'(dst_addr) == prev_addr && longint'(dst_bytes) == prev_len,
            "R10 hold", dst_addr, prev_addr);
      end
      prev_stall = dst_valid && !dst_ready;
      prev_addr  = dst_addr;
      prev_len   = dst_bytes;

      if (dst_valid && dst_ready) begin
        longint a, l;
        a = dst_addr; l = dst_bytes;
        chk(l <= MAXB && l > 0, "R2 length", l, MAXB);
        chk((a / 4096) == ((a + l - 1) / 4096), "R3 4k", (a + l - 1) / 4096, a / 4096);
        if (m_busy) begin
          pieces[m_id]++;
          if (last) m_busy = 0;
          else begin
            m_addr  += piece;
            m_rem   -= piece;
            m_first = 0;
          end
        end
      end

      if (src_valid && src_ready && job_a.size() > 0) begin
        longint a, l;
        a = job_a.pop_front(); l = job_l.pop_front();
        pieces[acc_id] = 0;
        if (l != 0) begin
          m_busy = 1; m_first = 1; m_addr = a; m_rem = l; m_id = acc_id;
        end
        acc_id++;
      end

      if (src_valid && !(src_ready)) nx_valid = 1;
      else nx_valid = (job_a.size() > 0) && ($urandom_range(0, 3) != 0);
      if (job_a.size() > 0) begin
        nx_addr = job_a[0]; nx_len = job_l[0];
      end
      nx_ready = ($urandom_range(0, 99) < ready_pct);
    end
  end

  always @(posedge clk) begin
    #1;
    if (run) begin
      src_valid <= nx_valid;
      src_addr  <= ADDR_W'(nx_addr);
      src_bytes <= LEN_W'(nx_len);
      dst_ready <= nx_ready;
    end
  end

  initial begin
    int cyc;
    job_a.push_back(128);    job_l.push_back(256);  // job 0: R11
    job_a.push_back(512);    job_l.push_back(200);  // job 1: R8
    job_a.push_back(1000);   job_l.push_back(0);    // job 2: R7
    job_a.push_back(32'hFF0); job_l.push_back(64);  // job 3: R3
    job_a.push_back(0);      job_l.push_back(1024); // job 4: R5
    job_a.push_back(16);     job_l.push_back(768);  // job 5: R4
    for (int i = 0; i < 300; i++) begin
      job_a.push_back($urandom_range(0, 65535));
      job_l.push_back((i % 17 == 0) ? 0 : $urandom_range(1, 2000));
    end

    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(dst_valid == 0, "R1 dst_valid", dst_valid, 0);
    chk(src_ready == 1, "R1 src_ready", src_ready, 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(dst_valid == 0, "R1 dst_valid after", dst_valid, 0);
    chk(src_ready == 1, "R1 src_ready after", src_ready, 1);
    run = 1;

    cyc = 0;
    while (!(job_a.size() == 0 && !m_busy) && cyc < 150000) begin
      @(posedge clk);
      cyc++;
      if (cyc == 1500) ready_pct = 40;
      if (cyc == 6000) ready_pct = 85;
    end
    if (cyc >= 150000) chk(0, "R6 watchdog", cyc, 150000);
    repeat (5) @(posedge clk);
    run = 0;

    chk(pieces[0] == 2, "R11 piece count", pieces[0], 2);
    chk(pieces[1] == 1, "R8 piece count", pieces[1], 1);
    chk(pieces[2] == 0, "R7 piece count", pieces[2], 0);
    chk(pieces[3] == 2, "R3 piece count", pieces[3], 2);
    chk(pieces[4] == 4, "R5 piece count", pieces[4], 4);
    chk(pieces[5] == 4, "R4 piece count", pieces[5], 4);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule